// File: doc/BRIEF.md
# Three-Tap FIR Filter with Carry-Save Product Reduction

This block is a clocked three-tap finite impulse response filter for unsigned data. Each accepted sample is combined with the two samples accepted before it. The output is the weighted sum `coef0*x[n] + coef1*x[n-1] + coef2*x[n-2]`. The three weights come in on input ports. They are used as they stand at the edge where a sample is accepted.

The three tap products are formed side by side. They are never added in pairs. Instead, one column of (3,2) counters reduces the three products to a sum vector and a carry vector. The sum bit of each column is the XOR of its three inputs, and the carry bit is their majority. A single carry-propagate adder then adds the sum vector to the carry vector shifted left by one place. The result is written to an output register.

The critical path is therefore one multiplier, one full-adder level and one final adder. The history registers shift only on cycles that carry a sample, so the filter can be fed a stream with gaps.

Top module: `fir3_csa`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `out_valid` is 0 and `out_data` is 0.
- R2: For each sample accepted at a clock edge, the edge stores `coef0*in_sample + coef1*x[n-1] + coef2*x[n-2]` into `out_data`. Here x[n-1] and x[n-2] are the two samples accepted before it, and all values are unsigned.
- R3: The output never wraps. With all inputs at 255, `out_data` equals 195075, which fits the 18-bit output.
- R4: A cycle with `in_valid` low does not move the history, and it leaves `out_data` unchanged. The next accepted sample still sees the samples accepted before the gap.
- R5: Reset clears the history to zero. The first output after reset is `coef0*x0`, and the second is `coef0*x1 + coef1*x0`.
- R6: `out_valid` is high in exactly the cycle after each edge at which `in_valid` was high, and it is low otherwise.
- R7: The carry-save layer keeps the value: sum vector plus twice the carry vector equals the sum of the three products. The sum bit is the XOR of the three inputs, and the carry bit is their majority.
- R8: The coefficients are used at the edge where a sample is accepted. A change to them appears in the result of the next accepted sample and does not alter an output already produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is present this cycle |
| in_sample | input | 8 | Unsigned input sample |
| coef0 | input | 8 | Weight of the newest sample |
| coef1 | input | 8 | Weight of the previous sample |
| coef2 | input | 8 | Weight of the sample two steps back |
| out_valid | output | 1 | `out_data` holds a new result |
| out_data | output | 18 | Registered filter result |

## Verification
Every result is due exactly one rising edge after the edge that accepts its sample. The bench drives `in_valid`, the sample and the coefficients on the falling edge. It reads `out_valid` and `out_data` on the following falling edge, which falls half a period after the edge that produced them.

For idle cycles the same one-edge offset is used. At that point the bench expects `out_valid` low and `out_data` unchanged. A later accepted sample then confirms that the history did not move.

Expected values come from a bench-side model of the two-sample history and the weighted sum. That model is updated only when the bench itself presents a sample.

// File: rtl/fir3_pkg.sv
package fir3_pkg;

  localparam int TAP_COUNT = 3;

  // Two-of-three vote used as the carry of a (3,2) counter.
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/fir3_history.sv
module fir3_history #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         shift_en,
  input  logic [DATA_W-1:0]            din,
  output logic [DEPTH-1:0][DATA_W-1:0] hist
);

  logic [DEPTH-1:0][DATA_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) begin
        hist_q[i] <= hist_q[i-1];
      end
    end
  end

  assign hist = hist_q;

  // R4: a cycle without a sample leaves the history untouched
  assert_hist_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist_q));

  // R2: an accepted sample becomes the newest history entry
  assert_hist_load_R2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (hist_q[0] == $past(din)));

endmodule

// File: rtl/fir3_csa_layer.sv
module fir3_csa_layer
  import fir3_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  output logic [W-1:0] sum_vec,
  output logic [W-1:0] carry_vec
);

  // One independent (3,2) counter per bit column; no carry moves between columns.
  for (genvar i = 0; i < W; i++) begin : g_col
    assign sum_vec[i]   = op_a[i] ^ op_b[i] ^ op_c[i];
    assign carry_vec[i] = maj3(op_a[i], op_b[i], op_c[i]);
  end

endmodule

// File: rtl/fir3_cpa.sv
module fir3_cpa #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 18
) (
  input  logic [IN_W-1:0]  sum_vec,
  input  logic [IN_W-1:0]  carry_vec,
  output logic [OUT_W-1:0] result
);

  localparam int PAD_S = OUT_W - IN_W;
  localparam int PAD_C = OUT_W - IN_W - 1;

  // The carry vector carries twice the weight of its column.
  assign result = {{PAD_S{1'b0}}, sum_vec} + {{PAD_C{1'b0}}, carry_vec, 1'b0};

endmodule

// File: rtl/fir3_csa.sv
module fir3_csa
  import fir3_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [SAMPLE_W-1:0]          in_sample,
  input  logic [COEF_W-1:0]            coef0,
  input  logic [COEF_W-1:0]            coef1,
  input  logic [COEF_W-1:0]            coef2,
  output logic                         out_valid,
  output logic [SAMPLE_W+COEF_W+1:0]   out_data
);

  localparam int PROD_W  = SAMPLE_W + COEF_W;
  localparam int OUT_W   = PROD_W + 2;
  localparam int HIST_D  = TAP_COUNT - 1;
  localparam logic [OUT_W-1:0] MAX_SUM =
    OUT_W'(TAP_COUNT) * OUT_W'((1 << SAMPLE_W) - 1) * OUT_W'((1 << COEF_W) - 1);

  logic [HIST_D-1:0][SAMPLE_W-1:0]    hist;
  logic [TAP_COUNT-1:0][SAMPLE_W-1:0] tap_x;
  logic [TAP_COUNT-1:0][COEF_W-1:0]   tap_h;
  logic [TAP_COUNT-1:0][PROD_W-1:0]   prod;
  logic [PROD_W-1:0]                  sum_vec, carry_vec;
  logic [OUT_W-1:0]                   total;

  fir3_history #(.DATA_W(SAMPLE_W), .DEPTH(HIST_D)) u_hist (
    .clk(clk), .rst(rst), .shift_en(in_valid), .din(in_sample), .hist(hist)
  );

  // The newest tap reads the incoming sample, the older taps read the history.
  assign tap_x[0] = in_sample;
  for (genvar t = 1; t < TAP_COUNT; t++) begin : g_tapx
    assign tap_x[t] = hist[t-1];
  end
  assign tap_h[0] = coef0;
  assign tap_h[1] = coef1;
  assign tap_h[2] = coef2;

  // All products are formed in parallel.
  for (genvar t = 0; t < TAP_COUNT; t++) begin : g_mul
    assign prod[t] = PROD_W'(tap_x[t]) * PROD_W'(tap_h[t]);
  end

  fir3_csa_layer #(.W(PROD_W)) u_csa (
    .op_a(prod[0]), .op_b(prod[1]), .op_c(prod[2]),
    .sum_vec(sum_vec), .carry_vec(carry_vec)
  );

  fir3_cpa #(.IN_W(PROD_W), .OUT_W(OUT_W)) u_cpa (
    .sum_vec(sum_vec), .carry_vec(carry_vec), .result(total)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= total;
    end
  end

  // R7: the redundant pair keeps the value of the three products
  assert_csa_conserve_R7: assert property (@(posedge clk) disable iff (rst)
    (OUT_W'(sum_vec) + {1'b0, carry_vec, 1'b0}) ==
    (OUT_W'(prod[0]) + OUT_W'(prod[1]) + OUT_W'(prod[2])));

  // R6: a valid flag follows each accepted sample by one edge
  assert_valid_follow_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R6: no valid flag without an accepted sample
  assert_valid_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R4: an idle cycle holds the output
  assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // R3: the result never exceeds the largest possible sum
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data <= MAX_SUM));

endmodule

// File: tb/fir3_csa_bench.sv
module fir3_csa_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_sample = '0;
  logic [7:0]  c0 = '0, c1 = '0, c2 = '0;
  logic        out_valid;
  logic [17:0] out_data;

  int tests = 0;
  int fails = 0;
  logic [7:0] m1 = '0, m2 = '0;
  logic [17:0] last_out = '0;

  always #10 clk = ~clk;

  fir3_csa u_fir3_csa (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .coef0(c0), .coef1(c1), .coef2(c2),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one sample on the falling edge, read the result one edge later.
  task automatic send(input logic [7:0] s, input string req);
    logic [31:0] exp;
    exp = c0 * s + c1 * m1 + c2 * m2;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = s;
    @(negedge clk);
    in_valid = 1'b0;
    m2 = m1;
    m1 = s;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, {14'd0, out_data}, exp);
    last_out = out_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sample = 8'hA5;
      @(negedge clk);
      check("R6 idle valid", {31'd0, out_valid}, 32'd0);
      check("R4 idle hold", {14'd0, out_data}, {14'd0, last_out});
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b1;
    in_sample = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset data", {14'd0, out_data}, 32'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 post-release valid", {31'd0, out_valid}, 32'd0);
    check("R1 post-release data", {14'd0, out_data}, 32'd0);
    m1 = '0; m2 = '0; last_out = '0;
  endtask

  task automatic t_reset_history();
    c0 = 8'd3; c1 = 8'd5; c2 = 8'd7;
    do_reset();
    send(8'd10, "R5 first output");   // 30
    send(8'd20, "R5 second output");  // 60 + 50
    send(8'd1,  "R2 third output");   // 3 + 100 + 70
  endtask

  task automatic t_random_stream();
    c0 = 8'd17; c1 = 8'd200; c2 = 8'd99;
    for (int i = 0; i < 40; i++) send(8'($urandom), "R2 random stream");
    c0 = 8'd255; c1 = 8'd1; c2 = 8'd128;
    for (int i = 0; i < 40; i++) send(8'($urandom), "R7 random stream");
  endtask

  task automatic t_gaps();
    c0 = 8'd2; c1 = 8'd11; c2 = 8'd101;
    send(8'd40, "R4 before gap");
    send(8'd50, "R4 before gap");
    idle(3);
    send(8'd60, "R4 after gap");
    send(8'd70, "R6 after gap");
    idle(1);
  endtask

  task automatic t_max();
    c0 = 8'd255; c1 = 8'd255; c2 = 8'd255;
    send(8'd255, "R3 max");
    send(8'd255, "R3 max");
    send(8'd255, "R3 max");
    check("R3 max exact", {14'd0, out_data}, 32'd195075);
  endtask

  task automatic t_coef_change();
    logic [17:0] held;
    c0 = 8'd1; c1 = 8'd1; c2 = 8'd1;
    send(8'd9, "R8 before change");
    held = out_data;
    @(negedge clk);
    c0 = 8'd100; c1 = 8'd0; c2 = 8'd0;
    @(negedge clk);
    check("R8 no effect on held output", {14'd0, out_data}, {14'd0, held});
    send(8'd3, "R8 after change");
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset_history();
    t_random_stream();
    t_gaps();
    t_max();
    t_coef_change();
    do_reset();
    send(8'd4, "R5 after second reset");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule